// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs read and write transactions to 16-bit registers inside an Ethernet PHY over a two-wire management bus. One wire is a clock the block generates. The other is a shared data line that the block drives through a tristate enable. A single-cycle request carries a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs one complete frame and reports the outcome with a one-cycle completion pulse.

The bus clock is the system clock divided by the even parameter `CLK_DIV`. Within each bus bit, the block changes its outgoing data while the bus clock is low and samples the incoming line at the rising edge. A read that gets no acknowledge from the PHY still runs to its full length, so every PHY on the bus stays aligned to the frame. The block then flags the error and returns zero data.

Top module: `mdioMaster`

## Requirements
- R1: After reset, and whenever no frame is running, `mdc` is low, `mdioOe` is low, `busy` is low and `done` is low.
- R2: Every frame drives, MSB first on the rising bus-clock edges, 32 ones, then the start code 01, then the opcode (10 for a read, 01 for a write), then the 5-bit PHY address, then the 5-bit register address.
- R3: A write frame continues with the turnaround code 10 and the 16 write-data bits MSB first, for 64 driven bits in total. It then gives one further bus clock with `mdioOe` low.
- R4: A read frame drives exactly 46 bits and releases the line after the register address. Bus clock 47 (counting from 1) is the turnaround. The line is sampled at the rising edge of bus clock 48: low means the PHY acknowledged.
- R5: After an acknowledged read, the line values at the rising edges of bus clocks 49 to 64 form `rdData`, MSB first, and `rdErr` is 0.
- R6: After a read with no acknowledge, the block still gives 16 data clocks and the closing clock. `rdData` is 0 and `rdErr` is 1.
- R7: Every frame is exactly 65 bus clocks long. `mdioOe` changes only while `mdc` is low, and the last bus clock is given with the line released.
- R8: Each bus clock period is `CLK_DIV` system cycles, with `mdc` high for `CLK_DIV/2` of them. `mdioOut` changes only while `mdc` is low.
- R9: `busy` is high from the cycle after a request is taken until the frame ends. A request made while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle at the end of a frame, and `busy` is low in that cycle. A write leaves `rdErr` at 0 and `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Single-cycle request strobe, taken when not busy |
| reqWrite | input | 1 | 1 for a write frame, 0 for a read frame |
| reqPhy | input | 5 | PHY address |
| reqReg | input | 5 | Register address inside the PHY |
| reqWdata | input | 16 | Data to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rdData | output | 16 | Data from the last read |
| rdErr | output | 1 | Last read got no acknowledge |
| mdc | output | 1 | Management bus clock |
| mdioOut | output | 1 | Outgoing data for the data pin |
| mdioOe | output | 1 | Output enable for the data pin |
| mdioIn | input | 1 | Value seen on the data pin |

## Verification
The assertions assume that `CLK_DIV` is even and at least 2. They also assume that `mdioIn` mirrors `mdioOut` while the block drives the pin, and otherwise shows the PHY's value or the pull-up level. The bench builds the pin that way: its PHY model drives the line only at the acknowledge and data clocks of a read, and leaves it high everywhere else. Requests are one cycle wide. Some are placed in the middle of a running frame, carrying other fields, to show they are ignored. The random frames draw the direction, the addresses, the data and whether the PHY answers.

// File: rtl/mdioPkg.sv
package mdioPkg;
  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int HDR_LEN   = 4 + 2 * ADDR_W;
  localparam int RD_DRIVE  = PRE_LEN + HDR_LEN;
  localparam int FRAME_W   = PRE_LEN + HDR_LEN + 2 + DATA_W;
  localparam int ACK_SLOT  = RD_DRIVE + 1;
  localparam int DATA_FIRST = ACK_SLOT + 1;
  localparam int DATA_LAST = DATA_FIRST + DATA_W - 1;
  localparam int SLOT_LAST = FRAME_W;

  localparam logic [1:0] CODE_START = 2'b01;
  localparam logic [1:0] CODE_RD    = 2'b10;
  localparam logic [1:0] CODE_WR    = 2'b01;
  localparam logic [1:0] CODE_TA    = 2'b10;

  typedef struct packed {
    logic load;
    logic shift;
    logic sampleAck;
    logic sampleBit;
    logic finish;
    logic isWrite;
  } mdioStrobeT;
endpackage

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioPkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       busy,
  output logic       done,
  output logic       mdc,
  output logic       mdioOe,
  output mdioStrobeT stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic          running;
  logic          isWr;
  logic [PW-1:0] phase;
  logic [6:0]    slot;
  logic          mdcR;
  logic          doneR;
  logic          accept;
  logic          riseEdge;
  logic          fallEdge;
  logic          lastSlot;

  assign accept   = !running && reqValid;
  assign riseEdge = running && (phase == PW'(HALF - 1));
  assign fallEdge = running && (phase == PW'(CLK_DIV - 1));
  assign lastSlot = (slot == 7'(SLOT_LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      isWr    <= 1'b0;
      phase   <= '0;
      slot    <= '0;
      mdcR    <= 1'b0;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (accept) begin
        running <= 1'b1;
        isWr    <= reqWrite;
        phase   <= '0;
        slot    <= '0;
        mdcR    <= 1'b0;
      end else if (running) begin
        if (fallEdge) begin
          phase <= '0;
          mdcR  <= 1'b0;
          if (lastSlot) begin
            running <= 1'b0;
            doneR   <= 1'b1;
          end else begin
            slot <= slot + 7'd1;
          end
        end else begin
          phase <= phase + PW'(1);
          if (riseEdge) mdcR <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.load      = accept;
    stb.shift     = fallEdge;
    stb.sampleAck = riseEdge && !isWr && (slot == 7'(ACK_SLOT));
    stb.sampleBit = riseEdge && !isWr && (slot >= 7'(DATA_FIRST)) && (slot <= 7'(DATA_LAST));
    stb.finish    = fallEdge && lastSlot;
    stb.isWrite   = isWr;
  end

  assign busy   = running;
  assign done   = doneR;
  assign mdc    = mdcR;
  assign mdioOe = running && (slot < (isWr ? 7'(FRAME_W) : 7'(RD_DRIVE)));
endmodule

// File: rtl/mdioDp.sv
module mdioDp
  import mdioPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobeT        stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqPhy,
  input  logic [ADDR_W-1:0] reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);
  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;
  logic               ackOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      ackOk   <= 1'b0;
      rdData  <= '0;
      rdErr   <= 1'b0;
    end else begin
      if (stb.load) begin
        txShift <= {{PRE_LEN{1'b1}}, CODE_START, (reqWrite ? CODE_WR : CODE_RD),
                    reqPhy, reqReg, CODE_TA, reqWdata};
        rxShift <= '0;
        ackOk   <= 1'b0;
      end else begin
        if (stb.shift) txShift <= {txShift[FRAME_W-2:0], 1'b0};
        if (stb.sampleAck) ackOk <= !mdioIn;
        if (stb.sampleBit && ackOk) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
        if (stb.finish) begin
          rdErr <= !stb.isWrite && !ackOk;
          if (!stb.isWrite) rdData <= rxShift;
        end
      end
    end
  end

  assign mdioOut = txShift[FRAME_W-1];
endmodule

// File: rtl/mdioMaster.sv
module mdioMaster
  import mdioPkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [4:0]  reqPhy,
  input  logic [4:0]  reqReg,
  input  logic [15:0] reqWdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        rdErr,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobeT stb;

  mdioCtrl #(.CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busy(busy), .done(done), .mdc(mdc), .mdioOe(mdioOe), .stb(stb)
  );

  mdioDp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWdata(reqWdata),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .rdData(rdData), .rdErr(rdErr)
  );
endmodule

// File: rtl/mdioMasterChk.sv
module mdioMasterChk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdioOe,
  input logic mdioOut
);
  localparam int HALF = CLK_DIV / 2;
  logic [7:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN) hiCnt <= '0;
    else if (mdc) hiCnt <= (hiCnt == 8'hFF) ? hiCnt : hiCnt + 8'd1;
    else hiCnt <= '0;
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) !busy |-> (!mdc && !mdioOe));
  // R8
  mdc_high_chk: assert property (@(posedge clk) disable iff (!rstN) mdc |-> (hiCnt < 8'(HALF)));
  // R8
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN) mdc |-> $stable(mdioOut));
  // R7
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rstN) !$stable(mdioOe) |-> !mdc);
endmodule

bind mdioMaster mdioMasterChk #(.CLK_DIV(CLK_DIV)) chk0 (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .mdc(mdc), .mdioOe(mdioOe), .mdioOut(mdioOut)
);

// File: tb/sim_mdioMaster.sv
module sim_mdioMaster;
  localparam int CLK_DIV = 4;
  localparam int HALF = CLK_DIV / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [4:0] reqPhy = '0, reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic busy, done, rdErr, mdc, mdioOut, mdioOe, mdioIn;
  logic [15:0] rdData;

  int checks = 0, fails = 0;
  int sysCnt = 0, riseCnt = 0, oeCnt = 0, goodGaps = 0, hiCycles = 0, lastRise = 0;
  logic [63:0] cap = '0;
  int baseRise = 0;
  logic phyResp = 1'b1;
  logic [15:0] phyData = '0;
  logic [15:0] expRd = '0;
  logic phyDrive;

  always #10 clk = ~clk;

  mdioMaster #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdData(rdData), .rdErr(rdErr),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: slot index is the count of rising edges seen so far in the frame
  always_comb begin
    int rel;
    rel = riseCnt - baseRise;
    phyDrive = 1'b1;
    if (rel == 47) phyDrive = !phyResp;
    else if (rel >= 48 && rel <= 63 && phyResp) phyDrive = phyData[63 - rel];
  end
  assign mdioIn = mdioOe ? mdioOut : phyDrive;

  always @(posedge clk) begin
    sysCnt <= sysCnt + 1;
    if (mdc) hiCycles <= hiCycles + 1;
  end

  always @(posedge mdc) begin
    riseCnt <= riseCnt + 1;
    if (sysCnt - lastRise == CLK_DIV) goodGaps <= goodGaps + 1;
    lastRise <= sysCnt;
    if (mdioOe) begin
      cap <= {cap[62:0], mdioOut};
      oeCnt <= oeCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input bit wr, input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
  endfunction

  task automatic runFrame(input bit wr, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d, input bit resp, input logic [15:0] pd, input bit poke);
    int r0, o0, g0, h0, cyc, doneCnt;
    logic [63:0] ef;
    @(negedge clk);
    phyResp = resp; phyData = pd;
    baseRise = riseCnt;
    r0 = riseCnt; o0 = oeCnt; g0 = goodGaps; h0 = hiCycles;
    reqWrite = wr; reqPhy = p; reqReg = r; reqWdata = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R9 busy after request", {63'd0, busy}, 64'd1);
    if (poke) begin
      repeat (37) @(negedge clk);
      reqWrite = !wr; reqPhy = ~p; reqReg = ~r; reqWdata = ~d; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R10 done reached", {63'd0, done}, 64'd1);
    chk(busy == 1'b0, "R10 busy low with done", {63'd0, busy}, 64'd0);
    ef = expFrame(wr, p, r, d);
    chk(riseCnt - r0 == 65, "R7 bus clocks per frame", 64'(riseCnt - r0), 64'd65);
    chk(goodGaps - g0 == 64, "R8 bus clock period", 64'(goodGaps - g0), 64'd64);
    chk(hiCycles - h0 == 65 * HALF, "R8 mdc high time", 64'(hiCycles - h0), 64'(65 * HALF));
    if (wr) begin
      chk(oeCnt - o0 == 64, "R3 driven bits in write", 64'(oeCnt - o0), 64'd64);
      chk(cap == ef, "R2 R3 write frame bits", cap, ef);
      chk(rdErr == 1'b0, "R10 write clears error", {63'd0, rdErr}, 64'd0);
      chk(rdData == expRd, "R10 write keeps read data", {48'd0, rdData}, {48'd0, expRd});
    end else begin
      chk(oeCnt - o0 == 46, "R4 driven bits in read", 64'(oeCnt - o0), 64'd46);
      chk(cap[45:0] == ef[63:18], "R2 R4 read header bits", {18'd0, cap[45:0]}, {18'd0, ef[63:18]});
      expRd = resp ? pd : 16'h0000;
      chk(rdData == expRd, resp ? "R5 read data" : "R6 no-ack data", {48'd0, rdData}, {48'd0, expRd});
      chk(rdErr == !resp, resp ? "R5 error flag" : "R6 error flag", {63'd0, rdErr}, {63'd0, !resp});
    end
    doneCnt = 0;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", {63'd0, done}, 64'd0);
    chk(!mdc && !mdioOe, "R1 idle bus", {62'd0, mdc, mdioOe}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdioOe, "R1 reset state",
        {60'd0, busy, done, mdc, mdioOe}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mdc && !mdioOe, "R1 after reset",
        {60'd0, busy, done, mdc, mdioOe}, 64'd0);
    runFrame(1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b1, 16'h0, 1'b0);
    runFrame(1'b0, 5'h1F, 5'h1F, 16'h0, 1'b1, 16'hBEEF, 1'b0);
    runFrame(1'b0, 5'h00, 5'h02, 16'h0, 1'b0, 16'h1234, 1'b0);
    runFrame(1'b0, 5'h05, 5'h11, 16'h0, 1'b1, 16'hFFFF, 1'b0);
    runFrame(1'b0, 5'h05, 5'h11, 16'h0, 1'b1, 16'h0001, 1'b1); // R9 ignored request
    runFrame(1'b1, 5'h1A, 5'h0C, 16'h0000, 1'b1, 16'h0, 1'b1); // R9 ignored request
    runFrame(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 1'b1, 16'h0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      runFrame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
               ($urandom % 4) != 0, 16'($urandom), ($urandom % 5) == 0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule